// File: doc/BRIEF.md
# Flagged FIFO with Overflow Latch

This block is a single-clock first-in first-out queue that holds 1024 words of 9 bits, a byte together with its parity bit. Its storage is a dual-port array. A write counter picks the slot that the next accepted word goes into, and a read counter picks the slot that the next read takes out. A producer and a consumer can both act in the same clock cycle. The block keeps an occupancy count and derives empty, full and half-full status from it. The half-full status also drives an interrupt request. A consumer that services the interrupt can then drain a large batch of words in one go while room is still left for new arrivals.

A mode input decides what happens to a write that arrives while the queue is full. In reject mode the write is dropped. In overwrite mode the oldest word is discarded, so the queue always holds the newest 1024 words. In either mode a write strobe that meets a full queue, with no read in the same cycle, sets a sticky overflow bit. This bit stays set until the host pulses a clear input. A read attempted on an empty queue has no effect on the queue and produces a one-cycle underflow pulse.

Top module: `flag_fifo`

## Requirements
- R1: After synchronous reset, empty is 1 and full, half, irq, ovf and udf are all 0.
- R2: Words leave in the order they were accepted. The word for an accepted read appears on rd_data in the clock cycle after the read. A read and a write in the same cycle both take effect.
- R3: Starting from empty with no reads, full is 0 after 1023 writes and 1 after exactly 1024 writes. empty is 1 exactly when occupancy is 0.
- R4: One read from a full queue, with no write in that cycle, clears full.
- R5: half is 1 exactly when occupancy is 512 or more, and irq always equals half.
- R6: With ovw_mode = 0, a write to a full queue without a read is dropped. Occupancy and stored contents stay unchanged.
- R7: With ovw_mode = 1, a write to a full queue without a read discards the oldest word and stores the new one. Occupancy stays at 1024.
- R8: ovf becomes 1 in the cycle after a write strobe meets a full queue with no accepted read. It stays 1 until ovf_clr is pulsed. A new overflow in the same cycle as ovf_clr wins over the clear.
- R9: A read on an empty queue leaves contents and read order unchanged, produces no data, and makes udf 1 for exactly the next cycle.
- R10: A read and a write in the same cycle on a full queue are both accepted, in either mode. Occupancy stays at 1024 and ovf is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 9 | Word from the last accepted read |
| ovw_mode | input | 1 | Policy when full: 0 reject, 1 overwrite oldest |
| ovf_clr | input | 1 | Clears the sticky overflow bit |
| full | output | 1 | Occupancy equals 1024 |
| empty | output | 1 | Occupancy is zero |
| half | output | 1 | Occupancy is 512 or more |
| irq | output | 1 | Interrupt request, follows half |
| ovf | output | 1 | Sticky overflow indicator |
| udf | output | 1 | One-cycle pulse after a read on an empty queue |

## Verification
The hardest cases to reach are the ones that happen only at the top boundary. These are a dropped or overwriting write, the combined read and write at full occupancy, and the overflow clear. Each needs the queue packed with exactly 1024 words first. The stimulus fills the queue word by word, then applies each full-state case in both modes, and only then drains the queue. This way any word that was wrongly lost or wrongly kept shows up in the drained order, where the scoreboard compares it against its model queue.

// File: rtl/ffq_pkg.sv
package ffq_pkg;

    localparam int WORD_W = 9;
    localparam int DEPTH  = 1024;

    typedef enum logic {
        POL_REJECT    = 1'b0,
        POL_OVERWRITE = 1'b1
    } full_policy_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic half;
    } occ_flags_t;

    function automatic occ_flags_t flags_of(input int unsigned n, input int unsigned depth);
        occ_flags_t f;
        f.full  = (n == depth);
        f.empty = (n == 0);
        f.half  = (n >= depth / 2);
        return f;
    endfunction

endpackage

// File: rtl/ffq_ram.sv
module ffq_ram #(
    parameter int W     = 9,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read-before-write when both ports hit the same slot
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/ffq_ptr.sv
module ffq_ptr #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/ffq_occ.sv
module ffq_occ
    import ffq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic       dec,
    output occ_flags_t flags
);
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else if (inc && !dec) count <= count + CW'(1);
        else if (dec && !inc) count <= count - CW'(1);
    end

    assign flags = flags_of(32'(count), DEPTH);
endmodule

// File: rtl/flag_fifo.sv
module flag_fifo
    import ffq_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = ffq_pkg::DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic         ovw_mode,
    input  logic         ovf_clr,
    output logic         full,
    output logic         empty,
    output logic         half,
    output logic         irq,
    output logic         ovf,
    output logic         udf
);
    occ_flags_t   st;
    full_policy_e policy;
    logic [AW-1:0] wptr, rptr;
    logic rd_ok, drop, wr_ok, collide;

    assign policy  = full_policy_e'(ovw_mode);
    assign rd_ok   = rd_en && !st.empty;
    assign collide = wr_en && st.full && !rd_ok;
    assign drop    = collide && (policy == POL_OVERWRITE);
    assign wr_ok   = wr_en && (!st.full || rd_ok || drop);

    ffq_ptr #(.DEPTH(DEPTH)) u_wptr (.clk(clk), .rst(rst), .adv(wr_ok),         .ptr(wptr));
    ffq_ptr #(.DEPTH(DEPTH)) u_rptr (.clk(clk), .rst(rst), .adv(rd_ok || drop), .ptr(rptr));

    ffq_occ #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst(rst), .inc(wr_ok && !drop), .dec(rd_ok), .flags(st)
    );

    ffq_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst(rst),
        .we(wr_ok), .waddr(wptr), .wdata(wr_data),
        .re(rd_ok), .raddr(rptr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)          ovf <= 1'b0;
        else if (collide) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) udf <= 1'b0;
        else     udf <= rd_en && st.empty;
    end

    assign full  = st.full;
    assign empty = st.empty;
    assign half  = st.half;
    assign irq   = st.half;
endmodule

// File: rtl/ffq_chk.sv
module ffq_chk #(
    parameter int W = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         rd_en,
    input logic [W-1:0] rd_data,
    input logic         ovw_mode,
    input logic         ovf_clr,
    input logic         full,
    input logic         empty,
    input logic         half,
    input logic         irq,
    input logic         ovf,
    input logic         udf
);
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst) !(full && empty));
    p_full_half_r5:  assert property (@(posedge clk) disable iff (rst) full |-> (half && irq));
    p_half_rise_r5:  assert property (@(posedge clk) disable iff (rst) $rose(half) |-> $past(wr_en));
    p_read_full_r4:  assert property (@(posedge clk) disable iff (rst)
                         (full && rd_en && !wr_en) |=> !full);
    p_reject_r6:     assert property (@(posedge clk) disable iff (rst)
                         (full && wr_en && !rd_en && !ovw_mode) |=> (full && $stable(rd_data)));
    p_overwrite_r7:  assert property (@(posedge clk) disable iff (rst)
                         (full && wr_en && !rd_en && ovw_mode) |=> full);
    p_ovf_set_r8:    assert property (@(posedge clk) disable iff (rst)
                         (full && wr_en && !rd_en) |=> ovf);
    p_ovf_hold_r8:   assert property (@(posedge clk) disable iff (rst)
                         (ovf && !ovf_clr) |=> ovf);
    p_udf_r9:        assert property (@(posedge clk) disable iff (rst)
                         (empty && rd_en) |=> udf);
    p_udf_pulse_r9:  assert property (@(posedge clk) disable iff (rst)
                         (!empty && !rd_en) |=> !udf);
    p_both_full_r10: assert property (@(posedge clk) disable iff (rst)
                         (full && rd_en && wr_en && !ovf) |=> (full && !ovf));
endmodule

bind flag_fifo ffq_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .ovw_mode(ovw_mode), .ovf_clr(ovf_clr), .full(full), .empty(empty),
    .half(half), .irq(irq), .ovf(ovf), .udf(udf)
);

// File: tb/sim_flag_fifo.sv
`timescale 1ns/1ps
module sim_flag_fifo;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, ovw_mode = 1'b0, ovf_clr = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic full, empty, half, irq, ovf, udf;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] mq[$];
    logic [8:0] exp_q[$];
    bit ovf_m = 0, udf_m = 0;

    always #5 clk = ~clk;

    flag_fifo u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .ovw_mode(ovw_mode), .ovf_clr(ovf_clr), .full(full),
        .empty(empty), .half(half), .irq(irq), .ovf(ovf), .udf(udf)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop and compare of read data (R2)
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk("R2", "rd_data order", 32'(rd_data), 32'(e));
        end
    end

    // driver: one cycle of stimulus, model update, flag checks
    task automatic step(input logic w, input logic [8:0] d, input logic r, input logic clr);
        int n;
        bit fl, rok;
        wr_en = w; wr_data = d; rd_en = r; ovf_clr = clr;
        @(posedge clk);
        n   = mq.size();
        fl  = (n == DEPTH);
        rok = r && (n > 0);
        if (rok) exp_q.push_back(mq.pop_front());
        if (w) begin
            if (!fl || rok) mq.push_back(d);
            else if (ovw_mode) begin
                void'(mq.pop_front());
                mq.push_back(d);
            end
        end
        udf_m = r && (n == 0);
        if (w && fl && !rok) ovf_m = 1;
        else if (clr)        ovf_m = 0;
        @(negedge clk);
        wr_en = 0; rd_en = 0; ovf_clr = 0;
        chk("R3", "full",  32'(full),  32'(mq.size() == DEPTH));
        chk("R3", "empty", 32'(empty), 32'(mq.size() == 0));
        chk("R5", "half",  32'(half),  32'(mq.size() >= DEPTH / 2));
        chk("R5", "irq",   32'(irq),   32'(mq.size() >= DEPTH / 2));
        chk("R8", "ovf",   32'(ovf),   32'(ovf_m));
        chk("R9", "udf",   32'(udf),   32'(udf_m));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "empty", 32'(empty), 1);
        chk("R1", "full",  32'(full),  0);
        chk("R1", "half",  32'(half),  0);
        chk("R1", "irq",   32'(irq),   0);
        chk("R1", "ovf",   32'(ovf),   0);
        chk("R1", "udf",   32'(udf),   0);

        // R3 fill with no reads, reject mode
        ovw_mode = 0;
        for (int i = 0; i < DEPTH - 1; i++) step(1, 9'(i * 37 + 5), 0, 0);
        chk("R3", "full after 1023", 32'(full), 0);
        step(1, 9'h0F0, 0, 0);
        chk("R3", "full after 1024", 32'(full), 1);

        // R6 rejected write, R8 sticky overflow and clear
        step(1, 9'h1AA, 0, 0);
        chk("R6", "full kept", 32'(full), 1);
        chk("R8", "ovf set", 32'(ovf), 1);
        step(0, 0, 0, 0);
        chk("R8", "ovf sticky", 32'(ovf), 1);
        step(1, 9'h1AB, 0, 1);
        chk("R8", "set beats clear", 32'(ovf), 1);
        step(0, 0, 0, 1);
        chk("R8", "ovf cleared", 32'(ovf), 0);

        // R10 read and write together while full, both modes
        step(1, 9'h155, 1, 0);
        chk("R10", "full kept mode0", 32'(full), 1);
        chk("R10", "no ovf mode0", 32'(ovf), 0);
        ovw_mode = 1;
        step(1, 9'h0AA, 1, 0);
        chk("R10", "full kept mode1", 32'(full), 1);
        chk("R10", "no ovf mode1", 32'(ovf), 0);

        // R7 overwrite oldest
        for (int i = 0; i < 3; i++) step(1, 9'(9'h1C0 + i), 0, 0);
        chk("R7", "full kept", 32'(full), 1);
        chk("R7", "ovf set", 32'(ovf), 1);
        step(0, 0, 0, 1);
        ovw_mode = 0;

        // R4 a single read clears full
        step(0, 0, 1, 0);
        chk("R4", "full cleared", 32'(full), 0);

        // R2 mixed traffic
        for (int i = 0; i < 300; i++) step(i % 3 != 0, 9'(i * 11), i % 2 == 0, 0);

        // drain, checking order of the newest words
        while (mq.size() > 0) step(0, 0, 1, 0);
        chk("R3", "empty after drain", 32'(empty), 1);

        // R9 read on empty
        step(0, 0, 1, 0);
        chk("R9", "udf pulse", 32'(udf), 1);
        step(0, 0, 0, 0);
        chk("R9", "udf one cycle", 32'(udf), 0);
        step(1, 9'h077, 1, 0);
        chk("R9", "write kept on empty read", 32'(empty), 0);
        step(0, 0, 1, 0);
        chk("R9", "word delivered", 32'(rd_data), 32'h077);
        step(0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule